// File: doc/BRIEF.md
# Accumulator ALU with Registered Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it takes two 8-bit operands and a 4-bit operation code. It presents an 8-bit result combinationally in the same cycle, with a strobe that says whether the caller should write that result back. When `op_en` is high, it latches new status flags at the clock edge. The status flags are a 2-bit condition code, carry/borrow, inter-digit (nibble) carry and signed overflow.

Two mode inputs shape the arithmetic. `with_carry` makes add, subtract and both rotates take part in the carry chain. `cmp_signed` picks a two's-complement reading for comparisons; otherwise operands are compared as unsigned values. The flag register is kept inside the block, so the carry that enters an operation is always the one the previous enabled operation left. A hidden bit records whether the last arithmetic operation was a subtraction, so that the decimal-adjust operation knows which correction to apply. Fetch, decode, register storage and memory access belong to the surrounding processor.

Top module: `acc_alu`

## Requirements
- R1: After a synchronous reset the condition code is 00 and carry, inter-digit carry and overflow are 0.
- R2: Codes 2 (AND), 3 (inclusive OR), 4 (exclusive OR) and 5 (load, result = `opnd_b`) give the logic result on `result`. They set the condition code from that result and leave carry, inter-digit carry and overflow unchanged.
- R3: The condition code from a result is 00 when the result is zero, 01 when it is nonzero with bit 7 clear, and 10 when bit 7 is set. The value 11 never appears.
- R4: Code 0 (add) gives `opnd_a + opnd_b`, plus the registered carry only when `with_carry` is 1. Carry becomes the carry out of bit 7, inter-digit carry the carry out of bit 3, and overflow the two's-complement overflow. The condition code follows the result.
- R5: Code 1 (subtract) gives `opnd_a - opnd_b`. When `with_carry` is 1 it also subtracts 1 if the registered carry is 0. Carry becomes 1 when no borrow occurs, inter-digit carry becomes 1 when the low nibble does not borrow, and overflow is the signed overflow. The condition code follows the result.
- R6: Code 6 (compare) sets the condition code to 00 for equal, 01 for `opnd_a` greater and 10 for `opnd_a` less. It compares unsigned when `cmp_signed` is 0 and signed when it is 1. It leaves the other flags unchanged.
- R7: Code 10 (test under mask) sets the condition code to 00 when every bit set in `opnd_b` is also set in `opnd_a`, and to 10 otherwise. It changes no other flag.
- R8: With `with_carry` = 1, code 7 (rotate left) and code 8 (rotate right) rotate the 9-bit value formed by the carry and `opnd_a`, and the carry takes the bit shifted out.
- R9: With `with_carry` = 0, rotates act on the 8-bit `opnd_a` alone and leave the carry unchanged. No rotate changes the condition code, inter-digit carry or overflow.
- R10: Code 9 (decimal adjust), when the last add or subtract was an add, adds 06 if inter-digit carry is 1 or the low nibble exceeds 9. It adds 60 if carry is 1 or the operand exceeds 99 hex, and ORs that high correction into carry. The condition code follows the result.
- R11: Code 9 after a subtract takes 06 away when inter-digit carry is 0 and 60 away when carry is 0. Carry is left unchanged and the condition code follows the result.
- R12: Flags hold when `op_en` is 0. Codes 11 to 15 change no flag and pass `opnd_a` to `result`.
- R13: `res_write` is 1 for codes 0 to 5 and 7 to 9, and 0 for compare, test under mask and codes 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Latch the flags produced by this cycle's operation |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand (register) |
| opnd_b | input | 8 | Second operand |
| with_carry | input | 1 | Include carry in add, subtract and rotates |
| cmp_signed | input | 1 | Signed comparison when 1 |
| result | output | 8 | Combinational result |
| res_write | output | 1 | Result is to be written back |
| cc_q | output | 2 | Registered condition code |
| carry_q | output | 1 | Registered carry / not-borrow |
| idc_q | output | 1 | Registered inter-digit carry |
| ovf_q | output | 1 | Registered overflow |

## Verification
A corrupted flag register shows up in two ways. It is visible on the flag ports one clock after the enabled operation that wrote it. It also appears on `result` in the very next cycle if that cycle performs a carry-chained add, subtract or rotate, because the stored carry feeds the result directly. A wrong hidden subtract marker is only visible when a decimal adjust follows. The reference model therefore follows every add and subtract with an adjust often enough to expose the wrong correction on `result` within the same cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_IOR   = 4'd3,
        OP_XOR   = 4'd4,
        OP_LOAD  = 4'd5,
        OP_CMP   = 4'd6,
        OP_ROTL  = 4'd7,
        OP_ROTR  = 4'd8,
        OP_DADJ  = 4'd9,
        OP_TMASK = 4'd10
    } alu_op_e;

    localparam logic [1:0] CC_ZERO = 2'b00;
    localparam logic [1:0] CC_POS  = 2'b01;
    localparam logic [1:0] CC_NEG  = 2'b10;

    typedef struct packed {
        logic [1:0] cc;
        logic       carry;
        logic       idc;
        logic       ovf;
        logic       after_sub;
    } flag_t;

    localparam flag_t FLAGS_RESET = '{cc: CC_ZERO, carry: 1'b0, idc: 1'b0,
                                      ovf: 1'b0, after_sub: 1'b0};

    function automatic logic [1:0] cc_of(input logic [DW-1:0] v);
        if (v == '0)
            return CC_ZERO;
        else if (v[DW-1])
            return CC_NEG;
        else
            return CC_POS;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          use_carry,
    input  logic          carry_in,
    output logic [DW-1:0] sum,
    output logic          co,
    output logic          half,
    output logic          ovf
);
    logic [DW-1:0] bx;
    logic          cin;
    logic [NW:0]   lo;
    logic [NW:0]   hi;

    always_comb begin
        bx = sub ? ~b : b;
        if (use_carry)
            cin = carry_in;
        else
            cin = sub;
        lo   = {1'b0, a[NW-1:0]}  + {1'b0, bx[NW-1:0]}  + {{NW{1'b0}}, cin};
        hi   = {1'b0, a[DW-1:NW]} + {1'b0, bx[DW-1:NW]} + {{NW{1'b0}}, lo[NW]};
        sum  = {hi[NW-1:0], lo[NW-1:0]};
        co   = hi[NW];
        half = lo[NW];
        ovf  = (a[DW-1] == bx[DW-1]) && (sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          with_carry,
    input  logic          cmp_signed,
    input  flag_t         cur,
    output logic [DW-1:0] result,
    output logic          res_write,
    output flag_t         nxt
);
    logic [DW-1:0] as_sum;
    logic          as_co, as_half, as_ovf;
    logic [1:0]    cmp_cc;
    logic          lo_fix, hi_fix;
    logic [DW-1:0] adj_res;

    acc_alu_addsub u_addsub (
        .a         (a),
        .b         (b),
        .sub       (op == OP_SUB),
        .use_carry (with_carry),
        .carry_in  (cur.carry),
        .sum       (as_sum),
        .co        (as_co),
        .half      (as_half),
        .ovf       (as_ovf)
    );

    always_comb begin
        if (a == b)
            cmp_cc = CC_ZERO;
        else if (cmp_signed ? ($signed(a) > $signed(b)) : (a > b))
            cmp_cc = CC_POS;
        else
            cmp_cc = CC_NEG;
    end

    always_comb begin
        if (cur.after_sub) begin
            lo_fix  = ~cur.idc;
            hi_fix  = ~cur.carry;
            adj_res = a - (lo_fix ? 8'h06 : 8'h00) - (hi_fix ? 8'h60 : 8'h00);
        end else begin
            lo_fix  = cur.idc   || (a[NW-1:0] > 4'd9);
            hi_fix  = cur.carry || (a > 8'h99);
            adj_res = a + (lo_fix ? 8'h06 : 8'h00) + (hi_fix ? 8'h60 : 8'h00);
        end
    end

    always_comb begin
        nxt       = cur;
        result    = a;
        res_write = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                result        = as_sum;
                res_write     = 1'b1;
                nxt.cc        = cc_of(as_sum);
                nxt.carry     = as_co;
                nxt.idc       = as_half;
                nxt.ovf       = as_ovf;
                nxt.after_sub = (op == OP_SUB);
            end
            OP_AND, OP_IOR, OP_XOR, OP_LOAD: begin
                case (op)
                    OP_AND:  result = a & b;
                    OP_IOR:  result = a | b;
                    OP_XOR:  result = a ^ b;
                    default: result = b;
                endcase
                res_write = 1'b1;
                nxt.cc    = cc_of(result);
            end
            OP_CMP:   nxt.cc = cmp_cc;
            OP_TMASK: nxt.cc = ((a & b) == b) ? CC_ZERO : CC_NEG;
            OP_ROTL: begin
                res_write = 1'b1;
                if (with_carry) begin
                    result    = {a[DW-2:0], cur.carry};
                    nxt.carry = a[DW-1];
                end else begin
                    result    = {a[DW-2:0], a[DW-1]};
                end
            end
            OP_ROTR: begin
                res_write = 1'b1;
                if (with_carry) begin
                    result    = {cur.carry, a[DW-1:1]};
                    nxt.carry = a[0];
                end else begin
                    result    = {a[0], a[DW-1:1]};
                end
            end
            OP_DADJ: begin
                result    = adj_res;
                res_write = 1'b1;
                nxt.cc    = cc_of(adj_res);
                if (!cur.after_sub)
                    nxt.carry = cur.carry | hi_fix;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
    import acc_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  flag_t nxt,
    output flag_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= FLAGS_RESET;
        else if (en)
            q <= nxt;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_en,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          with_carry,
    input  logic          cmp_signed,
    output logic [DW-1:0] result,
    output logic          res_write,
    output logic [1:0]    cc_q,
    output logic          carry_q,
    output logic          idc_q,
    output logic          ovf_q
);
    flag_t flags_q;
    flag_t flags_nxt;

    acc_alu_core u_core (
        .op         (alu_op_e'(op_sel)),
        .a          (opnd_a),
        .b          (opnd_b),
        .with_carry (with_carry),
        .cmp_signed (cmp_signed),
        .cur        (flags_q),
        .result     (result),
        .res_write  (res_write),
        .nxt        (flags_nxt)
    );

    acc_alu_flagreg u_flags (
        .clk (clk),
        .rst (rst),
        .en  (op_en),
        .nxt (flags_nxt),
        .q   (flags_q)
    );

    assign cc_q    = flags_q.cc;
    assign carry_q = flags_q.carry;
    assign idc_q   = flags_q.idc;
    assign ovf_q   = flags_q.ovf;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_en,
    input logic [3:0] op_sel,
    input logic       a_msb,
    input logic       with_carry,
    input logic       res_write,
    input logic [1:0] cc_q,
    input logic       carry_q,
    input logic       idc_q,
    input logic       ovf_q
);
    logic is_logic_like;
    assign is_logic_like = (op_sel == 4'd2) || (op_sel == 4'd3) || (op_sel == 4'd4) ||
                           (op_sel == 4'd5) || (op_sel == 4'd6) || (op_sel == 4'd10);

    // R3
    cc_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cc_q != 2'b11);

    // R2
    logic_keeps_arith_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && is_logic_like) |=> ($stable(carry_q) && $stable(idc_q) && $stable(ovf_q)));

    // R13
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_sel == 4'd6) || (op_sel == 4'd10) || (op_sel > 4'd10)) |-> !res_write);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> ($stable(cc_q) && $stable(carry_q) && $stable(idc_q) && $stable(ovf_q)));

    // R9
    rot_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && !with_carry && ((op_sel == 4'd7) || (op_sel == 4'd8)))
        |=> ($stable(carry_q) && $stable(cc_q) && $stable(idc_q) && $stable(ovf_q)));

    // R8
    rotl_carry_out_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && with_carry && (op_sel == 4'd7)) |=> (carry_q == $past(a_msb)));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_en      (op_en),
    .op_sel     (op_sel),
    .a_msb      (opnd_a[7]),
    .with_carry (with_carry),
    .res_write  (res_write),
    .cc_q       (cc_q),
    .carry_q    (carry_q),
    .idc_q      (idc_q),
    .ovf_q      (ovf_q)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_en = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic       with_carry = 1'b0;
    logic       cmp_signed = 1'b0;
    logic [7:0] result;
    logic       res_write;
    logic [1:0] cc_q;
    logic       carry_q, idc_q, ovf_q;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    int m_cc = 0, m_c = 0, m_idc = 0, m_ovf = 0, m_sub = 0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .op_en(op_en), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .with_carry(with_carry),
        .cmp_signed(cmp_signed), .result(result), .res_write(res_write),
        .cc_q(cc_q), .carry_q(carry_q), .idc_q(idc_q), .ovf_q(ovf_q)
    );

    function automatic int sg(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int ccof(int v);
        if (v == 0) return 0;
        return (v > 127) ? 2 : 1;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R4";
            1: return "R5";
            2, 3, 4, 5: return "R2";
            6: return "R6";
            7, 8: return "R8";
            9: return "R10";
            10: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(int op, int a, int b, int wc, int cs, int en);
        int er, ew, ncc, nc, nidc, novf, nsub, cin, s, sv, x, y;
        bit lo, hi;
        string tg;
        @(negedge clk);
        op_sel = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        with_carry = wc[0]; cmp_signed = cs[0]; op_en = en[0];
        #1;
        er = a; ew = 0; ncc = m_cc; nc = m_c; nidc = m_idc; novf = m_ovf; nsub = m_sub;
        tg = tag_of(op);
        case (op)
            0: begin
                cin = wc ? m_c : 0;
                s = a + b + cin; er = s % 256; ew = 1;
                nc = (s > 255); nidc = ((a % 16) + (b % 16) + cin) > 15;
                sv = sg(a) + sg(b) + cin; novf = (sv > 127) || (sv < -128);
                ncc = ccof(er); nsub = 0;
            end
            1: begin
                cin = wc ? (1 - m_c) : 0;
                s = a - b - cin; er = (s + 512) % 256; ew = 1;
                nc = (s >= 0); nidc = ((a % 16) - (b % 16) - cin) >= 0;
                sv = sg(a) - sg(b) - cin; novf = (sv > 127) || (sv < -128);
                ncc = ccof(er); nsub = 1;
            end
            2: begin er = a & b; ew = 1; ncc = ccof(er); end
            3: begin er = a | b; ew = 1; ncc = ccof(er); end
            4: begin er = a ^ b; ew = 1; ncc = ccof(er); end
            5: begin er = b;     ew = 1; ncc = ccof(er); end
            6: begin
                x = cs ? sg(a) : a; y = cs ? sg(b) : b;
                ncc = (x == y) ? 0 : ((x > y) ? 1 : 2);
            end
            7: begin
                ew = 1;
                if (wc) begin er = (a * 2) % 256 + m_c; nc = a / 128; end
                else begin er = (a * 2) % 256 + a / 128; tg = "R9"; end
            end
            8: begin
                ew = 1;
                if (wc) begin er = a / 2 + m_c * 128; nc = a % 2; end
                else begin er = a / 2 + (a % 2) * 128; tg = "R9"; end
            end
            9: begin
                ew = 1;
                if (m_sub == 0) begin
                    lo = (m_idc != 0) || ((a % 16) > 9);
                    hi = (m_c != 0) || (a > 153);
                    er = (a + (lo ? 6 : 0) + (hi ? 96 : 0)) % 256;
                    nc = (m_c != 0 || hi) ? 1 : 0;
                end else begin
                    tg = "R11";
                    er = (a - (m_idc != 0 ? 0 : 6) - (m_c != 0 ? 0 : 96) + 512) % 256;
                end
                ncc = ccof(er);
            end
            10: ncc = ((a & b) == b) ? 0 : 2;
            default: ;
        endcase
        chk(tg, "result", int'(result), er);
        chk("R13", "res_write", int'(res_write), ew);
        if (en != 0) begin
            m_cc = ncc; m_c = nc; m_idc = nidc; m_ovf = novf; m_sub = nsub;
        end else begin
            tg = "R12";
        end
        @(posedge clk); #1;
        chk(tg, "cc", int'(cc_q), m_cc);
        chk("R3", "cc_legal", int'(cc_q == 2'b11), 0);
        chk(tg, "carry", int'(carry_q), m_c);
        chk(tg, "idc", int'(idc_q), m_idc);
        chk(tg, "ovf", int'(ovf_q), m_ovf);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "cc", int'(cc_q), 0);
        chk("R1", "carry", int'(carry_q), 0);
        chk("R1", "idc", int'(idc_q), 0);
        chk("R1", "ovf", int'(ovf_q), 0);

        // R4 add: signed overflow, nibble carry, wrap to zero, carry-in
        apply(0, 8'h7F, 8'h01, 0, 0, 1);
        apply(0, 8'hFF, 8'h01, 0, 0, 1);
        apply(0, 8'h10, 8'h20, 1, 0, 1);
        apply(0, 8'h10, 8'h20, 0, 0, 1);
        // R5 subtract: borrow, borrow-in with carry mode
        apply(1, 8'h05, 8'h06, 0, 0, 1);
        apply(1, 8'h10, 8'h01, 1, 0, 1);
        apply(1, 8'h80, 8'h01, 0, 0, 1);
        // R2 logic ops keep arithmetic flags
        apply(2, 8'hF0, 8'h3C, 0, 0, 1);
        apply(3, 8'h00, 8'h00, 0, 0, 1);
        apply(4, 8'hAA, 8'h55, 0, 0, 1);
        apply(5, 8'h00, 8'h42, 0, 0, 1);
        // R6 compare unsigned vs signed
        apply(6, 8'h80, 8'h01, 0, 0, 1);
        apply(6, 8'h80, 8'h01, 0, 1, 1);
        apply(6, 8'h33, 8'h33, 0, 1, 1);
        // R7 test under mask
        apply(10, 8'hF3, 8'h30, 0, 0, 1);
        apply(10, 8'h03, 8'h30, 0, 0, 1);
        // R8 / R9 rotates
        apply(7, 8'h81, 8'h00, 1, 0, 1);
        apply(8, 8'h01, 8'h00, 1, 0, 1);
        apply(7, 8'h81, 8'h00, 0, 0, 1);
        apply(8, 8'h02, 8'h00, 0, 0, 1);
        // R10 decimal adjust after add: 38+45 -> 83
        apply(0, 8'h38, 8'h45, 0, 0, 1);
        apply(9, 8'h7D, 8'h00, 0, 0, 1);
        apply(0, 8'h99, 8'h01, 0, 0, 1);
        apply(9, 8'h9A, 8'h00, 0, 0, 1);
        // R11 decimal adjust after subtract: 42-15 -> 27
        apply(1, 8'h42, 8'h15, 0, 0, 1);
        apply(9, 8'h2D, 8'h00, 0, 0, 1);
        // R12 disabled op and unused codes
        apply(0, 8'hFF, 8'hFF, 0, 0, 0);
        apply(12, 8'h5A, 8'h00, 0, 0, 1);
        apply(15, 8'hA5, 8'hFF, 1, 1, 1);

        // mixed stream
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = (i % 4 == 3) ? 9 : int'($urandom_range(0, 15));
            apply(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                  ($urandom_range(0, 7) != 0) ? 1 : 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule